// File: doc/BRIEF.md
# Six-Bit Opcode ALU with Status Flags

This block is a purely combinational arithmetic logic unit for 6-bit data. A 4-bit opcode picks one of sixteen operations on operand A (and operand B where the operation has two inputs). The operations cover bitwise logic, rotates that either wrap within the word or pass through the carry, logical shifts, addition with or without the incoming carry, subtraction, increment and decrement. The block returns a 6-bit result and four flags: carry-out, signed overflow, zero and odd parity.

All arithmetic goes through one shared ripple adder. A multiplexer in front of it picks the adder's second operand (B, the complement of B, all zeros or all ones), and a second one picks its carry-in (0, 1 or the external carry). A final multiplexer selects the adder, logic or shift result. One opcode turns the unit off, and then every output is held at 0. The block has no clock and no state. A surrounding pipeline registers its inputs and outputs as it needs.

Top module: `alu6_core`

## Requirements
- R1: Opcode 0000 (idle) drives the result and all four flags to 0, whatever the other inputs are.
- R2: Opcodes 0001, 0010 and 0011 give A AND B, A OR B and A XOR B. Opcode 1010 gives NOT A. For all four, carry-out and overflow are 0.
- R3: Opcode 0111 gives A + B with the external carry-in ignored. Opcode 1000 gives A + B + carry-in. The carry-out is bit 6 of the 7-bit sum.
- R4: Opcode 1001 gives A + NOT B + 1, which is A − B. The carry-out is 1 exactly when A ≥ B unsigned, that is, when no borrow occurs.
- R5: Opcode 1011 gives A + 1, with carry-out 1 only for A = 111111. Opcode 1111 gives A + 111111, which is A − 1, with carry-out 0 only for A = 000000.
- R6: Overflow is set when the two's-complement result of opcodes 0111, 1000, 1001, 1011 and 1111 falls outside −32..31. It is 0 for every other opcode.
- R7: Opcode 0100 rotates A left inside the word: the result is {A[4:0], A[5]} and the carry-out is A[5]. Opcode 1100 rotates right: the result is {A[0], A[5:1]} and the carry-out is A[0].
- R8: Opcode 0101 rotates left through the carry: the result is {A[4:0], carry-in} and the carry-out is A[5]. Opcode 1101 rotates right through the carry: the result is {carry-in, A[5:1]} and the carry-out is A[0].
- R9: Opcode 0110 shifts left logically: the result is {A[4:0], 0} and the carry-out is A[5]. Opcode 1110 shifts right logically: the result is {0, A[5:1]} and the carry-out is A[0].
- R10: The zero flag is 1 exactly when the opcode is not 0000 and the 6-bit result is 000000.
- R11: The parity flag is the XOR of the six result bits, so it is 1 when the result holds an odd number of ones.
- R12: Operand B has no effect on the result or the flags of the unary opcodes (rotates, shifts, invert, increment, decrement).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 4 | Operation select |
| a_i | input | 6 | First operand |
| b_i | input | 6 | Second operand |
| carry_i | input | 1 | External carry-in |
| result_o | output | 6 | Operation result |
| carry_o | output | 1 | Carry-out flag |
| ovf_o | output | 1 | Signed overflow flag |
| zero_o | output | 1 | Result-is-zero flag |
| parity_o | output | 1 | Odd-parity flag |

## Verification
The hard cases involve two values arriving at the same time. A rotate through the carry has to bring in the carry-in bit and send out a different bit as the carry-out, and the overflow and carry flags of increment and decrement change only at the single operand values at the edges of the signed and unsigned ranges. Random operands seldom reach 011111 + 1 or 100000 − 1, and they seldom show that the add opcode without carry ignores a carry-in of 1. The bench therefore sweeps every opcode over all A, B and carry-in combinations against a model built from the requirements, then applies directed vectors at those boundary values and at results that give zero and odd parity.

// File: rtl/alu6_pkg.sv
// Package: shared opcode encoding and decoded control bundle for the ALU.
// Assumes a 4-bit opcode; the data width is a parameter of the modules.
package alu6_pkg;

    localparam int OPC_W = 4;

    // Opcode map; code values are architectural.
    typedef enum logic [OPC_W-1:0] {
        OP_IDLE = 4'h0, OP_AND = 4'h1, OP_OR  = 4'h2, OP_XOR = 4'h3,
        OP_ROL  = 4'h4, OP_RLC = 4'h5, OP_SHL = 4'h6, OP_ADD = 4'h7,
        OP_ADC  = 4'h8, OP_SUB = 4'h9, OP_NOT = 4'hA, OP_INC = 4'hB,
        OP_ROR  = 4'hC, OP_RRC = 4'hD, OP_SHR = 4'hE, OP_DEC = 4'hF
    } alu_op_e;

    // Which unit feeds the result.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ADDER = 2'd1,
        SRC_LOGIC = 2'd2,
        SRC_SHIFT = 2'd3
    } res_src_e;

    // Adder second-operand select.
    typedef enum logic [1:0] {
        BSEL_B    = 2'd0,
        BSEL_NOTB = 2'd1,
        BSEL_ZERO = 2'd2,
        BSEL_ONES = 2'd3
    } bsel_e;

    // Adder carry-in select.
    typedef enum logic [1:0] {
        CSEL_ZERO = 2'd0,
        CSEL_ONE  = 2'd1,
        CSEL_EXT  = 2'd2
    } csel_e;

    // Logic unit function.
    typedef enum logic [1:0] {
        LFN_AND = 2'd0,
        LFN_OR  = 2'd1,
        LFN_XOR = 2'd2,
        LFN_NOT = 2'd3
    } lfn_e;

    // What fills the vacated bit of a shift.
    typedef enum logic [1:0] {
        SH_LOGICAL = 2'd0,
        SH_WRAP    = 2'd1,
        SH_CARRY   = 2'd2
    } sh_mode_e;

    typedef struct packed {
        res_src_e src;
        bsel_e    bsel;
        csel_e    csel;
        lfn_e     lfn;
        sh_mode_e sh_mode;
        logic     sh_right;
    } alu_ctrl_t;

endpackage

// File: rtl/alu6_decoder.sv
// Module: alu6_decoder
// Turns the 4-bit opcode into the control bundle that steers the
// adder input muxes, the logic and shift units and the result mux.
// Assumes: purely combinational; every opcode value is defined.
module alu6_decoder
    import alu6_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output alu_ctrl_t        ctrl_o
);

    // Opcode table lookup.
    always_comb begin
        ctrl_o = '0;
        unique case (alu_op_e'(opcode_i))
            OP_IDLE: ctrl_o.src = SRC_NONE;
            OP_AND:  begin ctrl_o.src = SRC_LOGIC; ctrl_o.lfn = LFN_AND; end
            OP_OR:   begin ctrl_o.src = SRC_LOGIC; ctrl_o.lfn = LFN_OR;  end
            OP_XOR:  begin ctrl_o.src = SRC_LOGIC; ctrl_o.lfn = LFN_XOR; end
            OP_NOT:  begin ctrl_o.src = SRC_LOGIC; ctrl_o.lfn = LFN_NOT; end
            OP_ROL:  begin ctrl_o.src = SRC_SHIFT; ctrl_o.sh_mode = SH_WRAP;    ctrl_o.sh_right = 1'b0; end
            OP_RLC:  begin ctrl_o.src = SRC_SHIFT; ctrl_o.sh_mode = SH_CARRY;   ctrl_o.sh_right = 1'b0; end
            OP_SHL:  begin ctrl_o.src = SRC_SHIFT; ctrl_o.sh_mode = SH_LOGICAL; ctrl_o.sh_right = 1'b0; end
            OP_ROR:  begin ctrl_o.src = SRC_SHIFT; ctrl_o.sh_mode = SH_WRAP;    ctrl_o.sh_right = 1'b1; end
            OP_RRC:  begin ctrl_o.src = SRC_SHIFT; ctrl_o.sh_mode = SH_CARRY;   ctrl_o.sh_right = 1'b1; end
            OP_SHR:  begin ctrl_o.src = SRC_SHIFT; ctrl_o.sh_mode = SH_LOGICAL; ctrl_o.sh_right = 1'b1; end
            OP_ADD:  begin ctrl_o.src = SRC_ADDER; ctrl_o.bsel = BSEL_B;    ctrl_o.csel = CSEL_ZERO; end
            OP_ADC:  begin ctrl_o.src = SRC_ADDER; ctrl_o.bsel = BSEL_B;    ctrl_o.csel = CSEL_EXT;  end
            OP_SUB:  begin ctrl_o.src = SRC_ADDER; ctrl_o.bsel = BSEL_NOTB; ctrl_o.csel = CSEL_ONE;  end
            OP_INC:  begin ctrl_o.src = SRC_ADDER; ctrl_o.bsel = BSEL_ZERO; ctrl_o.csel = CSEL_ONE;  end
            OP_DEC:  begin ctrl_o.src = SRC_ADDER; ctrl_o.bsel = BSEL_ONES; ctrl_o.csel = CSEL_ZERO; end
            default: ctrl_o = '0;
        endcase
    end

    // Guard: only the idle code may leave the result unsourced (R1).
    always_comb begin
        p_idle_only_code_r1: assert ((ctrl_o.src == SRC_NONE) == (opcode_i == 4'h0))
            else $error("decoder: unsourced result on non-idle opcode");
    end

endmodule

// File: rtl/alu6_adder_path.sv
// Module: alu6_adder_path
// Shared adder with its operand-B and carry-in select muxes; yields
// sum, carry-out and signed overflow for every arithmetic opcode.
// Assumes: ripple-style sum is acceptable for the width in use.
module alu6_adder_path
    import alu6_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         carry_i,
    input  bsel_e        bsel_i,
    input  csel_e        csel_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] b_mux;
    logic         c_mux;
    logic [W:0]   total;

    // Second operand select.
    always_comb begin
        unique case (bsel_i)
            BSEL_B:    b_mux = b_i;
            BSEL_NOTB: b_mux = ~b_i;
            BSEL_ZERO: b_mux = '0;
            BSEL_ONES: b_mux = '1;
            default:   b_mux = b_i;
        endcase
    end

    // Carry-in select.
    always_comb begin
        unique case (csel_i)
            CSEL_ZERO: c_mux = 1'b0;
            CSEL_ONE:  c_mux = 1'b1;
            CSEL_EXT:  c_mux = carry_i;
            default:   c_mux = 1'b0;
        endcase
    end

    // Widened add; top bit is the carry-out.
    always_comb begin
        total  = {1'b0, a_i} + {1'b0, b_mux} + {{W{1'b0}}, c_mux};
        sum_o  = total[W-1:0];
        cout_o = total[W];
    end

    // Signed overflow: like-signed inputs yielding a different sign.
    always_comb begin
        ovf_o = (a_i[MSB] == b_mux[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end

    // Guard: subtract carry-out means no borrow (R4).
    always_comb begin
        if (bsel_i == BSEL_NOTB && csel_i == CSEL_ONE) begin
            p_sub_no_borrow_r4: assert (cout_o == (a_i >= b_i))
                else $error("adder: subtract carry disagrees with unsigned compare");
        end
    end

endmodule

// File: rtl/alu6_logic_unit.sv
// Module: alu6_logic_unit
// Bitwise AND, OR, XOR of A and B, or complement of A.
// Assumes: function select comes from the decoder.
module alu6_logic_unit
    import alu6_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  lfn_e         lfn_i,
    output logic [W-1:0] y_o
);

    // Per-bit function select, one slice per bit.
    for (genvar i = 0; i < W; i++) begin : g_slice
        always_comb begin
            unique case (lfn_i)
                LFN_AND: y_o[i] = a_i[i] & b_i[i];
                LFN_OR:  y_o[i] = a_i[i] | b_i[i];
                LFN_XOR: y_o[i] = a_i[i] ^ b_i[i];
                LFN_NOT: y_o[i] = ~a_i[i];
                default: y_o[i] = 1'b0;
            endcase
        end
    end

    // Guard: invert has no ones in common with its operand (R2).
    always_comb begin
        if (lfn_i == LFN_NOT) begin
            p_not_disjoint_r2: assert ((y_o & a_i) == '0)
                else $error("logic: invert overlaps operand");
        end
    end

endmodule

// File: rtl/alu6_shift_unit.sv
// Module: alu6_shift_unit
// One-position shift of A left or right; the vacated bit is filled
// with 0, the bit leaving the other end, or the external carry.
// The leaving bit is returned as the shift carry-out.
// Assumes: single-position moves only.
module alu6_shift_unit
    import alu6_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] a_i,
    input  logic         carry_i,
    input  logic         right_i,
    input  sh_mode_e     mode_i,
    output logic [W-1:0] y_o,
    output logic         out_bit_o
);

    localparam int MSB = W - 1;

    logic leave_bit;
    logic fill_bit;

    // Bit that drops off the end in the chosen direction.
    always_comb leave_bit = right_i ? a_i[0] : a_i[MSB];

    // Vacated-bit source.
    always_comb begin
        unique case (mode_i)
            SH_LOGICAL: fill_bit = 1'b0;
            SH_WRAP:    fill_bit = leave_bit;
            SH_CARRY:   fill_bit = carry_i;
            default:    fill_bit = 1'b0;
        endcase
    end

    // Per-bit neighbour select; end bits take the fill.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            always_comb y_o[i] = right_i ? a_i[i+1] : fill_bit;
        end else if (i == MSB) begin : g_msb
            always_comb y_o[i] = right_i ? fill_bit : a_i[i-1];
        end else begin : g_mid
            always_comb y_o[i] = right_i ? a_i[i+1] : a_i[i-1];
        end
    end

    always_comb out_bit_o = leave_bit;

    // Guard: a wrap rotate keeps the count of ones (R7).
    always_comb begin
        if (mode_i == SH_WRAP) begin
            p_rotate_keeps_ones_r7: assert ($countones(y_o) == $countones(a_i))
                else $error("shift: wrap rotate changed population");
        end
    end

endmodule

// File: rtl/alu6_flag_unit.sv
// Module: alu6_flag_unit
// Zero and parity flags from the selected result; zero is forced
// low while the unit is idle.
// Assumes: result is already zero when idle.
module alu6_flag_unit #(
    parameter int W = 6
) (
    input  logic [W-1:0] result_i,
    input  logic         active_i,
    output logic         zero_o,
    output logic         parity_o
);

    // All-zero detect, qualified by activity.
    always_comb zero_o = active_i && (result_i == '0);

    // Odd-ones detect.
    always_comb parity_o = ^result_i;

    // Guard: an all-zero result can never be odd (R10, R11).
    always_comb begin
        if (zero_o) begin
            p_zero_even_r10: assert (!parity_o && $countones(result_i) == 0)
                else $error("flags: zero flag with ones in result");
        end
    end

endmodule

// File: rtl/alu6_core.sv
// Module: alu6_core (top)
// Combinational opcode-driven ALU: decoder, shared adder path, logic
// unit, shift unit, result/carry/overflow muxes and flag unit.
// Assumes: no clock; callers register inputs and outputs as needed.
module alu6_core
    import alu6_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic             carry_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o,
    output logic             parity_o
);

    alu_ctrl_t    ctrl;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] log_y;
    logic [W-1:0] sh_y;
    logic         sh_out;
    logic         active;

    alu6_decoder u_dec (
        .opcode_i (opcode_i),
        .ctrl_o   (ctrl)
    );

    alu6_adder_path #(.W(W)) u_add (
        .a_i     (a_i),
        .b_i     (b_i),
        .carry_i (carry_i),
        .bsel_i  (ctrl.bsel),
        .csel_i  (ctrl.csel),
        .sum_o   (add_sum),
        .cout_o  (add_cout),
        .ovf_o   (add_ovf)
    );

    alu6_logic_unit #(.W(W)) u_log (
        .a_i   (a_i),
        .b_i   (b_i),
        .lfn_i (ctrl.lfn),
        .y_o   (log_y)
    );

    alu6_shift_unit #(.W(W)) u_sh (
        .a_i       (a_i),
        .carry_i   (carry_i),
        .right_i   (ctrl.sh_right),
        .mode_i    (ctrl.sh_mode),
        .y_o       (sh_y),
        .out_bit_o (sh_out)
    );

    // Result, carry and overflow select by source unit.
    always_comb begin
        unique case (ctrl.src)
            SRC_ADDER: begin result_o = add_sum; carry_o = add_cout; ovf_o = add_ovf; end
            SRC_LOGIC: begin result_o = log_y;   carry_o = 1'b0;     ovf_o = 1'b0;    end
            SRC_SHIFT: begin result_o = sh_y;    carry_o = sh_out;   ovf_o = 1'b0;    end
            default:   begin result_o = '0;      carry_o = 1'b0;     ovf_o = 1'b0;    end
        endcase
    end

    always_comb active = (ctrl.src != SRC_NONE);

    alu6_flag_unit #(.W(W)) u_flg (
        .result_i (result_o),
        .active_i (active),
        .zero_o   (zero_o),
        .parity_o (parity_o)
    );

    // Guard: idle opcode silences every output (R1).
    always_comb begin
        if (opcode_i == 4'h0) begin
            p_idle_quiet_r1: assert (result_o == '0 && !carry_o && !ovf_o && !zero_o && !parity_o)
                else $error("core: idle opcode produced activity");
        end
    end

    // Guard: plain add never sees the external carry (R3).
    always_comb begin
        if (opcode_i == 4'h7) begin
            p_add_ignores_cin_r3: assert (result_o == W'(a_i + b_i))
                else $error("core: add without carry used carry-in");
        end
    end

    // Guard: overflow only on arithmetic opcodes (R6).
    always_comb begin
        if (ovf_o) begin
            p_ovf_arith_only_r6: assert (opcode_i inside {4'h7, 4'h8, 4'h9, 4'hB, 4'hF})
                else $error("core: overflow on non-arithmetic opcode");
        end
    end

endmodule

// File: tb/sim_alu6_core.sv
// Directed bench: one task per scenario, each sweeping or poking its
// opcodes and comparing against a model derived from the requirements.
module sim_alu6_core;

    localparam int W = 6;

    logic         clk = 1'b0;
    logic [3:0]   opcode;
    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] result;
    logic         carry, ovf, zero, parity;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    alu6_core #(.W(W)) u0 (
        .opcode_i (opcode),
        .a_i      (a),
        .b_i      (b),
        .carry_i  (cin),
        .result_o (result),
        .carry_o  (carry),
        .ovf_o    (ovf),
        .zero_o   (zero),
        .parity_o (parity)
    );

    function automatic int sx(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - 64 : int'(v);
    endfunction

    // Model: returns {result, carry, ovf, zero, parity}.
    function automatic logic [W+3:0] model(input logic [3:0] op, input logic [W-1:0] x,
                                          input logic [W-1:0] y, input logic ci);
        logic [W-1:0] r = '0;
        logic c = 1'b0, v = 1'b0, z, p;
        int s = 0, ss = 0;
        bit arith = 1'b0;
        case (op)
            4'h1: r = x & y;
            4'h2: r = x | y;
            4'h3: r = x ^ y;
            4'hA: r = ~x;
            4'h4: begin r = {x[4:0], x[5]}; c = x[5]; end
            4'hC: begin r = {x[0], x[5:1]}; c = x[0]; end
            4'h5: begin r = {x[4:0], ci};   c = x[5]; end
            4'hD: begin r = {ci, x[5:1]};   c = x[0]; end
            4'h6: begin r = {x[4:0], 1'b0}; c = x[5]; end
            4'hE: begin r = {1'b0, x[5:1]}; c = x[0]; end
            4'h7: begin arith = 1; s = int'(x) + int'(y);          ss = sx(x) + sx(y); end
            4'h8: begin arith = 1; s = int'(x) + int'(y) + int'(ci); ss = sx(x) + sx(y) + int'(ci); end
            4'h9: begin arith = 1; s = int'(x) + (63 - int'(y)) + 1; ss = sx(x) - sx(y); end
            4'hB: begin arith = 1; s = int'(x) + 1;  ss = sx(x) + 1; end
            4'hF: begin arith = 1; s = int'(x) + 63; ss = sx(x) - 1; end
            default: ;
        endcase
        if (arith) begin
            r = W'(s);
            c = (s >= 64);
            v = (ss > 31) || (ss < -32);
        end
        z = (op != 4'h0) && (r == '0);
        p = ^r;
        return {r, c, v, z, p};
    endfunction

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'h0: return "R1";
            4'h1, 4'h2, 4'h3, 4'hA: return "R2";
            4'h7, 4'h8: return "R3";
            4'h9: return "R4";
            4'hB, 4'hF: return "R5";
            4'h4, 4'hC: return "R7";
            4'h5, 4'hD: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic ci);
        opcode = op; a = x; b = y; cin = ci;
        #1;
    endtask

    task automatic compare(input string req, input logic [W+3:0] exp);
        logic [W+3:0] act = {result, carry, ovf, zero, parity};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s op=%h a=%b b=%b cin=%b : actual {res,c,v,z,p}=%b expected %b",
                     req, opcode, a, b, cin, act, exp);
        end
    endtask

    task automatic sweep(input logic [3:0] op);
        for (int x = 0; x < 64; x++)
            for (int y = 0; y < 64; y++)
                for (int ci = 0; ci < 2; ci++) begin
                    apply(op, W'(x), W'(y), 1'(ci));
                    compare(tag(op), model(op, W'(x), W'(y), 1'(ci)));
                    #1;
                end
    endtask

    // R1: idle code silences everything.
    task automatic t_idle();
        apply(4'h0, '0, '0, 1'b0);
        compare("R1", '0);
        apply(4'h0, 6'b111111, 6'b101010, 1'b1);
        compare("R1", '0);
        sweep(4'h0);
    endtask

    // R2: bitwise logic and invert.
    task automatic t_logic();
        sweep(4'h1); sweep(4'h2); sweep(4'h3); sweep(4'hA);
    endtask

    // R3, R4, R5, R6: adder-based ops, full sweeps plus boundaries.
    task automatic t_arith();
        sweep(4'h7); sweep(4'h8); sweep(4'h9); sweep(4'hB); sweep(4'hF);
        apply(4'h7, 6'd5, 6'd9, 1'b1);                    // R3 cin ignored
        compare("R3", {6'd14, 1'b0, 1'b0, 1'b0, 1'b1});
        apply(4'hB, 6'b011111, 6'd0, 1'b0);               // R6 inc overflow
        compare("R6", {6'b100000, 1'b0, 1'b1, 1'b0, 1'b1});
        apply(4'hF, 6'b100000, 6'd0, 1'b0);               // R6 dec overflow
        compare("R6", {6'b011111, 1'b1, 1'b1, 1'b0, 1'b1});
        apply(4'hF, 6'd0, 6'd0, 1'b0);                    // R5 dec of zero
        compare("R5", {6'b111111, 1'b0, 1'b0, 1'b0, 1'b0});
        apply(4'hB, 6'b111111, 6'd0, 1'b0);               // R5 inc wraps, R10 zero
        compare("R5", {6'd0, 1'b1, 1'b0, 1'b1, 1'b0});
        apply(4'h9, 6'd3, 6'd4, 1'b0);                    // R4 borrow
        compare("R4", {6'b111111, 1'b0, 1'b0, 1'b0, 1'b0});
    endtask

    // R7, R8, R9: rotates and shifts, sweeps plus carry-injection pokes.
    task automatic t_shift();
        sweep(4'h4); sweep(4'hC); sweep(4'h5); sweep(4'hD); sweep(4'h6); sweep(4'hE);
        apply(4'h5, 6'b100000, 6'd0, 1'b1);               // R8 left through carry
        compare("R8", {6'b000001, 1'b1, 1'b0, 1'b0, 1'b1});
        apply(4'hD, 6'b000001, 6'd0, 1'b0);               // R8 right, zero result
        compare("R8", {6'b000000, 1'b1, 1'b0, 1'b1, 1'b0});
        apply(4'hE, 6'b000001, 6'd0, 1'b1);               // R9 cin ignored
        compare("R9", {6'b000000, 1'b1, 1'b0, 1'b1, 1'b0});
    endtask

    // R10, R11: zero and parity via logic results.
    task automatic t_flags();
        apply(4'h3, 6'b110101, 6'b110101, 1'b0);          // R10 zero
        compare("R10", {6'd0, 1'b0, 1'b0, 1'b1, 1'b0});
        apply(4'h2, 6'b000100, 6'b100001, 1'b0);          // R11 odd
        compare("R11", {6'b100101, 1'b0, 1'b0, 1'b0, 1'b1});
        apply(4'h1, 6'b110000, 6'b010011, 1'b1);          // R11 odd single
        compare("R11", {6'b010000, 1'b0, 1'b0, 1'b0, 1'b1});
    endtask

    // R12: B changes nothing for unary opcodes.
    task automatic t_b_ignored();
        logic [3:0] ops [10] = '{4'h4, 4'h5, 4'h6, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF, 4'hB};
        foreach (ops[k]) begin
            logic [W+3:0] first;
            apply(ops[k], 6'b101101, 6'd0, 1'b1);
            first = {result, carry, ovf, zero, parity};
            apply(ops[k], 6'b101101, 6'b111111, 1'b1);
            compare("R12", first);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        opcode = 4'h0; a = '0; b = '0; cin = 1'b0;
        #3;
        t_idle();
        t_logic();
        t_arith();
        t_shift();
        t_flags();
        t_b_ignored();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule